// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block scores a stream of data memory accesses against a tag-only model of a cache. It keeps a valid bit, a tag and a recency age for every line. It performs no data storage and no backing-memory traffic. Each access is classified as a hit, a miss, or a miss that displaces a valid line, and running totals are kept for each class. A cycle total is also kept, from which the average access time is obtained by dividing by the number of accesses.

The number of sets, the number of ways and the block size are elaboration-time parameters. One way gives a direct-mapped directory, and zero set bits give a fully associative one. Requests use a valid/ready handshake and carry a two-bit operation code and an address. A read-modify-write request is scored as two back-to-back accesses to the same address, so it produces two result pulses. Instruction fetches are accepted and then discarded.

Top module: `tag_dir_top`

## Requirements
- R1: The address is split, from the least significant bit upward, into OFFSET_BITS offset bits, SET_BITS set-index bits and the remaining tag bits. An access is a hit only when a valid line of the indexed set holds the same tag. Offset bits never affect the outcome.
- R2: On a miss, the new tag is installed in the indexed set. If the set contains any invalid line, the lowest-numbered invalid way is filled, and no eviction is reported.
- R3: On a miss in a full set, the least recently used line is replaced. A line counts as used when it is hit or filled.
- R4: `res_evict` is raised, and `evict_count` is advanced, only for a miss that displaces a valid line.
- R5: Operation code 0 (instruction fetch) is accepted but produces no result pulse. It changes neither the counters nor the directory contents.
- R6: Operation code 3 (modify) gives two result pulses on consecutive cycles. The second pulse is always a hit. `req_ready` is low in the cycle between the two pulses. Codes 1 (load) and 2 (store) give one pulse each.
- R7: `cycle_count` advances by HIT_CYCLES for every scored access, plus MISS_CYCLES for every miss. The defaults are 1 and 100.
- R8: Synchronous reset, active high, invalidates every line and clears every counter. It also clears the result flags and raises `req_ready`.
- R9: A result appears one cycle after its access is scored. Exactly one of `res_hit` and `res_miss` is high when `res_valid` is high, and all flags are low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 0 fetch, 1 load, 2 store, 3 modify |
| req_addr | input | ADDR_W | Byte address |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | Scored access hit |
| res_miss | output | 1 | Scored access missed |
| res_evict | output | 1 | Miss displaced a valid line |
| hit_count | output | CNT_W | Total hits |
| miss_count | output | CNT_W | Total misses |
| evict_count | output | CNT_W | Total evictions |
| cycle_count | output | CNT_W | Total access cycles |

## Verification
Directed sequences confine several tags to a single set. These show whether the directory separates a hit caused by an offset-only change from a cold fill, whether it fills a free way before evicting, and whether it evicts the least recently touched line rather than the oldest fill. Fetches aimed at a full set reveal whether an ignored operation still disturbs recency. Cold and warm modifies check the two-pulse scoring. A long random run then mixes all four operation codes over a small pool of tags, so that hits, fills and evictions interleave across sets. Every pulse and every counter is compared against a model in the bench that tracks recency with timestamps rather than ages.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;

  typedef enum logic [1:0] {
    OP_FETCH  = 2'd0,
    OP_LOAD   = 2'd1,
    OP_STORE  = 2'd2,
    OP_MODIFY = 2'd3
  } access_op_t;

  // cycles charged for one scored access
  function automatic int unsigned access_cost(logic miss, int unsigned hit_t, int unsigned pen);
    return hit_t + (miss ? pen : 0);
  endfunction

  function automatic logic is_scored(access_op_t op);
    return op != OP_FETCH;
  endfunction

  function automatic logic is_two_phase(access_op_t op);
    return op == OP_MODIFY;
  endfunction

endpackage

// File: rtl/tag_dir_store.sv
module tag_dir_store #(
  parameter int SETS  = 4,
  parameter int SET_W = 2,
  parameter int WAYS  = 2,
  parameter int TAG_W = 10,
  parameter int AGE_W = 1,
  parameter int WAY_W = 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [SET_W-1:0]                set_idx,
  input  logic                            upd_en,
  input  logic [WAY_W-1:0]                upd_way,
  input  logic [TAG_W-1:0]                upd_tag,
  output logic [WAYS-1:0]                 rd_valid,
  output logic [WAYS-1:0][TAG_W-1:0]      rd_tag,
  output logic [WAYS-1:0][AGE_W-1:0]      rd_age
);

  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic [WAYS-1:0]              valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]   tag_q   [SETS];
  logic [WAYS-1:0][AGE_W-1:0]   age_q   [SETS];

  assign rd_valid = valid_q[set_idx];
  assign rd_tag   = tag_q[set_idx];
  assign rd_age   = age_q[set_idx];

  // age the touched line held before the update; an invalid line counts as oldest
  logic [AGE_W-1:0] ref_age;
  assign ref_age = rd_valid[upd_way] ? rd_age[upd_way] : OLDEST;

  // lines at the oldest age, for the recency-permutation check
  logic [WAYS-1:0] oldest_vec;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      oldest_vec[w] = rd_valid[w] && (rd_age[w] == OLDEST);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        tag_q[s]   <= '0;
        age_q[s]   <= '0;
      end
    end else if (upd_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (upd_way == WAY_W'(w)) begin
          valid_q[set_idx][w] <= 1'b1;
          tag_q[set_idx][w]   <= upd_tag;
          age_q[set_idx][w]   <= '0;
        end else if (valid_q[set_idx][w] && (age_q[set_idx][w] < ref_age)) begin
          age_q[set_idx][w]   <= age_q[set_idx][w] + 1'b1;
        end
      end
    end
  end

  AST_FULL_SET_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst)
    (&rd_valid) |-> $onehot(oldest_vec)); // R3

endmodule

// File: rtl/tag_dir_match.sv
module tag_dir_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 10,
  parameter int AGE_W = 1,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]            rd_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] rd_tag,
  input  logic [WAYS-1:0][AGE_W-1:0] rd_age,
  input  logic [TAG_W-1:0]           look_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic [WAY_W-1:0]           victim_way,
  output logic                       victim_valid
);

  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic             have_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] old_way;

  always_comb begin
    hit       = 1'b0;
    hit_way   = '0;
    have_free = 1'b0;
    free_way  = '0;
    old_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rd_valid[w] && (rd_tag[w] == look_tag) && !hit) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!rd_valid[w] && !have_free) begin
        have_free = 1'b1;
        free_way  = WAY_W'(w);
      end
      if (rd_valid[w] && (rd_age[w] == OLDEST)) begin
        old_way = WAY_W'(w);
      end
    end
    victim_way   = have_free ? free_way : old_way;
    victim_valid = !have_free;
  end

endmodule

// File: rtl/tag_dir_stats.sv
module tag_dir_stats
  import cache_dir_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int HIT_CYCLES  = 1,
  parameter int MISS_CYCLES = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic             acc_miss,
  input  logic             acc_evict,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count,
  output logic [CNT_W-1:0] evict_count,
  output logic [CNT_W-1:0] cycle_count
);

  logic [CNT_W-1:0] step_cycles;
  assign step_cycles = CNT_W'(access_cost(acc_miss, HIT_CYCLES, MISS_CYCLES));

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_count   <= '0;
      miss_count  <= '0;
      evict_count <= '0;
      cycle_count <= '0;
    end else if (acc_en) begin
      if (acc_miss) miss_count <= miss_count + 1'b1;
      else          hit_count  <= hit_count + 1'b1;
      if (acc_evict) evict_count <= evict_count + 1'b1;
      cycle_count <= cycle_count + step_cycles;
    end
  end

  AST_CYCLES_MATCH_TOTALS: assert property (@(posedge clk) disable iff (rst)
    cycle_count == CNT_W'(HIT_CYCLES) * (hit_count + miss_count) + CNT_W'(MISS_CYCLES) * miss_count); // R7
  AST_EVICTS_WITHIN_MISSES: assert property (@(posedge clk) disable iff (rst)
    evict_count <= miss_count); // R4

endmodule

// File: rtl/tag_dir_top.sv
module tag_dir_top
  import cache_dir_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SET_BITS    = 2,
  parameter int WAYS        = 2,
  parameter int OFFSET_BITS = 4,
  parameter int CNT_W       = 32,
  parameter int HIT_CYCLES  = 1,
  parameter int MISS_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_evict,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  evict_count,
  output logic [CNT_W-1:0]  cycle_count
);

  localparam int SETS  = 1 << SET_BITS;
  localparam int SET_W = (SET_BITS > 0) ? SET_BITS : 1;
  localparam int TAG_W = ADDR_W - SET_BITS - OFFSET_BITS;
  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int WAY_W = AGE_W;

  access_op_t        op_in;
  logic              accept;
  logic              do_access;
  logic              second_q;
  logic [ADDR_W-1:0] hold_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  look_tag;

  logic [WAYS-1:0]            rd_valid;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0][AGE_W-1:0] rd_age;
  logic                       hit;
  logic [WAY_W-1:0]           hit_way;
  logic [WAY_W-1:0]           victim_way;
  logic                       victim_valid;
  logic [WAY_W-1:0]           upd_way;
  logic                       evict_now;

  assign op_in     = access_op_t'(req_op);
  assign req_ready = !second_q;
  assign accept    = req_valid && req_ready;
  assign do_access = second_q || (accept && is_scored(op_in));
  assign cur_addr  = second_q ? hold_q : req_addr;
  assign look_tag  = cur_addr[ADDR_W-1 -: TAG_W];

  generate
    if (SET_BITS > 0) begin : g_indexed
      assign set_idx = cur_addr[OFFSET_BITS +: SET_BITS];
    end else begin : g_single_set
      assign set_idx = '0;
    end
  endgenerate

  tag_dir_store #(
    .SETS(SETS), .SET_W(SET_W), .WAYS(WAYS),
    .TAG_W(TAG_W), .AGE_W(AGE_W), .WAY_W(WAY_W)
  ) store_i (
    .clk(clk), .rst(rst), .set_idx(set_idx),
    .upd_en(do_access), .upd_way(upd_way), .upd_tag(look_tag),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_age(rd_age)
  );

  tag_dir_match #(
    .WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W), .WAY_W(WAY_W)
  ) match_i (
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_age(rd_age), .look_tag(look_tag),
    .hit(hit), .hit_way(hit_way), .victim_way(victim_way), .victim_valid(victim_valid)
  );

  assign upd_way   = hit ? hit_way : victim_way;
  assign evict_now = do_access && !hit && victim_valid;

  tag_dir_stats #(
    .CNT_W(CNT_W), .HIT_CYCLES(HIT_CYCLES), .MISS_CYCLES(MISS_CYCLES)
  ) stats_i (
    .clk(clk), .rst(rst),
    .acc_en(do_access), .acc_miss(!hit), .acc_evict(evict_now),
    .hit_count(hit_count), .miss_count(miss_count),
    .evict_count(evict_count), .cycle_count(cycle_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      second_q  <= 1'b0;
      hold_q    <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_evict <= 1'b0;
    end else begin
      second_q  <= accept && is_two_phase(op_in);
      if (accept) hold_q <= req_addr;
      res_valid <= do_access;
      res_hit   <= do_access && hit;
      res_miss  <= do_access && !hit;
      res_evict <= evict_now;
    end
  end

  AST_SECOND_HALF_HITS: assert property (@(posedge clk) disable iff (rst)
    second_q |-> hit); // R6
  AST_SECOND_HALF_PULSE: assert property (@(posedge clk) disable iff (rst)
    second_q |=> (res_valid && res_hit)); // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $onehot({res_hit, res_miss})); // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !(res_hit || res_miss || res_evict)); // R9
  AST_EVICT_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    res_evict |-> res_miss); // R4

endmodule

// File: tb/tag_dir_top_tb_top.sv
module tag_dir_top_tb_top;

  localparam int ADDR_W = 16;
  localparam int SET_BITS = 2;
  localparam int WAYS = 2;
  localparam int OFFSET_BITS = 4;
  localparam int CNT_W = 32;
  localparam int HIT_CYCLES = 1;
  localparam int MISS_CYCLES = 100;
  localparam int SETS = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - SET_BITS - OFFSET_BITS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic res_valid, res_hit, res_miss, res_evict;
  logic [CNT_W-1:0] hit_count, miss_count, evict_count, cycle_count;

  always #10 clk = ~clk;

  tag_dir_top #(
    .ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .WAYS(WAYS), .OFFSET_BITS(OFFSET_BITS),
    .CNT_W(CNT_W), .HIT_CYCLES(HIT_CYCLES), .MISS_CYCLES(MISS_CYCLES)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss), .res_evict(res_evict),
    .hit_count(hit_count), .miss_count(miss_count),
    .evict_count(evict_count), .cycle_count(cycle_count)
  );

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  // reference model: timestamps instead of ages
  bit          m_valid [SETS][WAYS];
  int unsigned m_tag   [SETS][WAYS];
  longint      m_stamp [SETS][WAYS];
  longint      m_now = 0;
  int unsigned m_hits = 0, m_misses = 0, m_evicts = 0, m_cycles = 0;

  function automatic void model_clear();
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_valid[s][w] = 0; m_tag[s][w] = 0; m_stamp[s][w] = 0;
      end
    m_hits = 0; m_misses = 0; m_evicts = 0; m_cycles = 0;
  endfunction

  function automatic void model_access(input logic [ADDR_W-1:0] a, output bit h, output bit e);
    int s, t, pick;
    longint best;
    s = (a >> OFFSET_BITS) % SETS;
    t = a >> (OFFSET_BITS + SET_BITS);
    h = 0; e = 0; pick = -1;
    m_now++;
    for (int w = 0; w < WAYS; w++)
      if (!h && m_valid[s][w] && m_tag[s][w] == t) begin h = 1; pick = w; end
    if (!h) begin
      for (int w = WAYS - 1; w >= 0; w--) if (!m_valid[s][w]) pick = w;
      if (pick < 0) begin
        best = m_stamp[s][0]; pick = 0;
        for (int w = 1; w < WAYS; w++)
          if (m_stamp[s][w] < best) begin best = m_stamp[s][w]; pick = w; end
        e = 1;
      end
    end
    m_valid[s][pick] = 1; m_tag[s][pick] = t; m_stamp[s][pick] = m_now;
    if (h) m_hits++; else m_misses++;
    if (e) m_evicts++;
    m_cycles += HIT_CYCLES + (h ? 0 : MISS_CYCLES);
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(int t, int s, int off);
    return ADDR_W'((t << (OFFSET_BITS + SET_BITS)) | (s << OFFSET_BITS) | off);
  endfunction

  task automatic check_counts(string req);
    vectors++;
    if (hit_count !== CNT_W'(m_hits) || miss_count !== CNT_W'(m_misses) ||
        evict_count !== CNT_W'(m_evicts) || cycle_count !== CNT_W'(m_cycles)) begin
      fails++;
      $display("FAIL %s counters actual h=%0d m=%0d e=%0d c=%0d expected h=%0d m=%0d e=%0d c=%0d",
               req, hit_count, miss_count, evict_count, cycle_count,
               m_hits, m_misses, m_evicts, m_cycles);
    end
  endtask

  task automatic check_pulse(string req, bit eh, bit ee);
    vectors++;
    if (res_valid !== 1'b1 || res_hit !== eh || res_miss !== !eh || res_evict !== ee) begin
      fails++;
      $display("FAIL %s result actual v=%b h=%b m=%b e=%b expected v=1 h=%b m=%b e=%b",
               req, res_valid, res_hit, res_miss, res_evict, eh, !eh, ee);
    end
    check_counts(req);
  endtask

  task automatic do_op(input logic [1:0] op, input logic [ADDR_W-1:0] a, input string req);
    bit h, e;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (op == 2'd0) begin
      vectors++;
      if (res_valid !== 1'b0) begin
        fails++;
        $display("FAIL %s fetch pulse actual v=%b expected v=0", req, res_valid);
      end
      check_counts(req);
    end else begin
      model_access(a, h, e);
      check_pulse(req, h, e);
      if (op == 2'd3) begin
        vectors++;
        if (req_ready !== 1'b0) begin
          fails++;
          $display("FAIL R6 ready during modify actual %b expected 0", req_ready);
        end
        @(negedge clk);
        model_access(a, h, e);
        check_pulse(req, h, e);
      end
    end
  endtask

  task automatic expect_flags(string req, bit eh, bit ee);
    vectors++;
    if (res_hit !== eh || res_evict !== ee) begin
      fails++;
      $display("FAIL %s directed actual h=%b e=%b expected h=%b e=%b", req, res_hit, res_evict, eh, ee);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    vectors++;
    if (res_valid !== 1'b0 || req_ready !== 1'b1 || res_hit !== 1'b0 || res_miss !== 1'b0 || res_evict !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset state actual v=%b rdy=%b h=%b m=%b e=%b expected v=0 rdy=1 h=0 m=0 e=0",
               res_valid, req_ready, res_hit, res_miss, res_evict);
    end
    check_counts("R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    apply_reset();                                          // R8

    // R2: cold fill, free way first
    do_op(2'd1, mk_addr(1, 0, 0), "R2");  expect_flags("R2", 0, 0);
    // R1: offset change within block hits
    do_op(2'd1, mk_addr(1, 0, 9), "R1");  expect_flags("R1", 1, 0);
    do_op(2'd2, mk_addr(2, 0, 3), "R2");  expect_flags("R2", 0, 0);
    do_op(2'd1, mk_addr(1, 0, 15), "R1"); expect_flags("R1", 1, 0);
    // R3: tag 2 is least recent, tag 3 evicts it
    do_op(2'd2, mk_addr(3, 0, 0), "R3");  expect_flags("R4", 0, 1);
    do_op(2'd1, mk_addr(1, 0, 0), "R3");  expect_flags("R3", 1, 0);
    do_op(2'd1, mk_addr(2, 0, 0), "R3");  expect_flags("R3", 0, 1);
    // R5: fetches leave directory and counters untouched
    do_op(2'd0, mk_addr(7, 0, 0), "R5");
    do_op(2'd0, mk_addr(8, 0, 0), "R5");
    do_op(2'd1, mk_addr(1, 0, 0), "R5");  expect_flags("R5", 1, 0);
    do_op(2'd1, mk_addr(2, 0, 0), "R5");  expect_flags("R5", 1, 0);
    // R6: cold modify is miss then hit, warm modify is two hits
    do_op(2'd3, mk_addr(5, 1, 4), "R6");
    do_op(2'd3, mk_addr(5, 1, 8), "R6");  expect_flags("R6", 1, 0);
    // R7: counters checked at every pulse
    check_counts("R7");

    // R8: reset forgets cached lines
    apply_reset();
    do_op(2'd1, mk_addr(1, 0, 0), "R8");  expect_flags("R8", 0, 0);

    // random mix; R9 flags and R3/R4/R7 counts compared at every pulse
    for (int i = 0; i < 600; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      do_op(op, mk_addr($urandom_range(0, 4), $urandom_range(0, SETS - 1), $urandom_range(0, 15)), "R9");
    end
    check_counts("R7");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule